// File: doc/BRIEF.md
# Real-Time Clock Register File

This block is the byte-wide register file of a real-time clock. Software first writes a register number to an address port and then reads or writes that register through a data port. Registers 0x00 to 0x09 hold the clock and calendar bytes. Registers 0x0A to 0x0D are four status registers. The oscillator divider and the time-keeping logic sit outside this block, so the time bytes here change only through the data port or through a parallel set-time load.

Two status registers are checked strictly. Register 0x0A accepts only its one time-base setting. Register 0x0B must keep binary and 24-hour mode set, so only two of its bits may change. Any other write is dropped and raises a one-cycle error pulse. Bit 6 of register 0x0B switches a periodic tick generator on and off. While it runs, the generator pulses an interrupt line every `INTERVAL` clock cycles. Reading register 0x0A flips its update-in-progress bit on every read, so a polling loop sees the bit change.

Top module: `rtc_regfile`

## Requirements
- R1: An address-port write of 0x00 to 0x0D selects that register on the next edge. An address-port write above 0x0D is ignored and the earlier selection stays.
- R2: Registers 0x00 to 0x09 are plain bytes that can be written and read back. Read data appears on `rd_data` one cycle after the `rd_en` strobe.
- R3: After reset, register 0x0A holds 0x26 and register 0x0B holds 0x46. The ten clock bytes are zero, `irq` and `err` are low, and the tick generator is idle.
- R4: Each read of register 0x0A inverts its bit 7 and returns the inverted value. The first read after reset returns 0xA6 and the second returns 0x26.
- R5: Reads of registers 0x0C and 0x0D return 0x00. A write to either register is dropped and drives `err` high for exactly one cycle.
- R6: A write of 0x26 to register 0x0A is stored, which also clears bit 7. Any other value is dropped and pulses `err`.
- R7: A write to register 0x0B is stored only if bits 2 and 1 are set and bits 7, 5, 4 and 0 are clear. Bit 6 (periodic enable) and bit 3 (square-wave enable) may take either value. Any other write is dropped and pulses `err`.
- R8: An accepted 0x0B write with bit 6 set starts an idle generator. The first one-cycle `irq` pulse comes `INTERVAL` cycles after the write edge, and further pulses follow every `INTERVAL` cycles. Writing bit 6 set while the generator runs keeps its phase.
- R9: An accepted 0x0B write with bit 6 clear stops the generator. No `irq` pulse follows, not even one due in that same cycle.
- R10: A `load_en` pulse stores the seconds, minutes, hours, weekday, day, month and year inputs into bytes 0, 2, 4, 6, 7, 8 and 9 in that order. The weekday input (0 to 6) is stored plus one and the month input (0 to 11) is stored plus one. When a data write in the same cycle targets one of these seven bytes, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_we | input | 1 | Address write strobe |
| addr_in | input | 8 | Register number to select |
| wr_en | input | 1 | Data write strobe for the selected register |
| wr_data | input | 8 | Data to write |
| rd_en | input | 1 | Data read strobe for the selected register |
| rd_data | output | 8 | Read result, valid one cycle after `rd_en` |
| load_en | input | 1 | Set-time load strobe |
| ld_sec | input | 8 | Seconds to load |
| ld_min | input | 8 | Minutes to load |
| ld_hour | input | 8 | Hours to load |
| ld_wday | input | 3 | Weekday to load, 0 to 6 |
| ld_mday | input | 8 | Day of month to load |
| ld_mon | input | 4 | Month to load, 0 to 11 |
| ld_year | input | 8 | Year to load |
| irq | output | 1 | Periodic interrupt, a one-cycle pulse |
| err | output | 1 | One-cycle pulse when a status-register write is dropped |

## Verification
The tick generator can expire in the same cycle that software writes register 0x0B to stop it. In that case the stop must win and no pulse may appear. The bench starts the generator, counts edges until the cycle in which its counter reaches zero, and lands a write that clears bit 6 on exactly that edge. It then watches `irq` for several intervals and expects no pulse. The same approach covers a set-time load that meets a data-port write to the seconds byte on one edge, where the value read back must be the loaded one.

// File: rtl/rtc_regfile.sv
module rtc_regfile #(
  parameter int INTERVAL = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_we,
  input  logic [7:0] addr_in,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       load_en,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  input  logic [2:0] ld_wday,
  input  logic [7:0] ld_mday,
  input  logic [3:0] ld_mon,
  input  logic [7:0] ld_year,
  output logic       irq,
  output logic       err
);
  localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);
  localparam int NTOD = 10;
  localparam logic [3:0] SA = 4'hA, SB = 4'hB, SC = 4'hC, SD = 4'hD;
  localparam logic [7:0] A_CFG = 8'h26;
  localparam logic [7:0] B_RST = 8'h46;

  logic [3:0]    sel;
  logic [7:0]    tod [NTOD];
  logic [7:0]    reg_a, reg_b;
  logic          run;
  logic [CW-1:0] cnt;
  logic [7:0]    rd_val;

  wire in_tod  = sel < 4'(NTOD);
  wire wr_a    = wr_en && sel == SA;
  wire wr_b    = wr_en && sel == SB;
  wire a_ok    = wr_data == A_CFG;
  wire b_ok    = (wr_data & 8'hB7) == 8'h06;
  wire wr_bad  = (wr_a && !a_ok) || (wr_b && !b_ok) || (wr_en && (sel == SC || sel == SD));
  wire b_take  = wr_b && b_ok;
  wire start_g = b_take && wr_data[6] && !run;
  wire stop_g  = b_take && !wr_data[6];

  always_comb begin
    if (in_tod)         rd_val = tod[sel];
    else if (sel == SA) rd_val = {~reg_a[7], reg_a[6:0]};
    else if (sel == SB) rd_val = reg_b;
    else                rd_val = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel     <= '0;
      for (int i = 0; i < NTOD; i++) tod[i] <= '0;
      reg_a   <= A_CFG;
      reg_b   <= B_RST;
      run     <= 1'b0;
      cnt     <= '0;
      irq     <= 1'b0;
      err     <= 1'b0;
      rd_data <= '0;
    end else begin
      if (addr_we && addr_in <= 8'h0D) sel <= addr_in[3:0];
      err <= wr_bad;
      irq <= run && cnt == '0 && !stop_g;
      if (rd_en) rd_data <= rd_val;
      if (rd_en && sel == SA) reg_a[7] <= ~reg_a[7];
      if (wr_a && a_ok) reg_a <= wr_data;
      if (b_take) reg_b <= wr_data;
      if (wr_en && in_tod) tod[sel] <= wr_data;
      if (load_en) begin
        tod[0] <= ld_sec;
        tod[2] <= ld_min;
        tod[4] <= ld_hour;
        tod[6] <= {5'd0, ld_wday} + 8'd1;
        tod[7] <= ld_mday;
        tod[8] <= {4'd0, ld_mon} + 8'd1;
        tod[9] <= ld_year;
      end
      if (stop_g) run <= 1'b0;
      else if (start_g) begin
        run <= 1'b1;
        cnt <= RELOAD;
      end else if (run) cnt <= (cnt == '0) ? RELOAD : cnt - 1'b1;
    end
  end

  p_sel_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sel <= 4'hD);
  p_sel_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we && addr_in > 8'h0D |=> $stable(sel));
  p_uip_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && sel == SA && !wr_en |=> rd_data[7] != $past(reg_a[7]));
  p_cd_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (sel == SC || sel == SD) |=> rd_data == 8'h00);
  p_cd_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (sel == SC || sel == SD) |=> err);
  p_a_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_a[6:0] == A_CFG[6:0]);
  p_b_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_b & 8'hB7) == 8'h06);
  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_b && b_ok && !wr_data[6] |=> !irq && !run);
endmodule

// File: tb/test_rtc_regfile.sv
module test_rtc_regfile;
  localparam int IV = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic addr_we = 0, wr_en = 0, rd_en = 0, load_en = 0;
  logic [7:0] addr_in = 0, wr_data = 0, rd_data;
  logic [7:0] ld_sec = 0, ld_min = 0, ld_hour = 0, ld_mday = 0, ld_year = 0;
  logic [2:0] ld_wday = 0;
  logic [3:0] ld_mon = 0;
  logic irq, err;
  int checks = 0, fails = 0;
  logic [7:0] rv;
  logic       ev;

  always #5 clk = ~clk;

  rtc_regfile #(.INTERVAL(IV)) i_rtc_regfile (
    .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .addr_in(addr_in),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .load_en(load_en), .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour),
    .ld_wday(ld_wday), .ld_mday(ld_mday), .ld_mon(ld_mon), .ld_year(ld_year),
    .irq(irq), .err(err));

  // {err expected, address, write data, read-back expected}
  localparam logic [24:0] VEC [9] = '{
    {1'b0, 8'h00, 8'h3B, 8'h3B},
    {1'b0, 8'h09, 8'h63, 8'h63},
    {1'b0, 8'h05, 8'hFF, 8'hFF},
    {1'b1, 8'h0C, 8'h55, 8'h00},
    {1'b1, 8'h0D, 8'hAA, 8'h00},
    {1'b0, 8'h0B, 8'h0E, 8'h0E},
    {1'b1, 8'h0B, 8'h07, 8'h0E},
    {1'b1, 8'h0B, 8'h02, 8'h0E},
    {1'b1, 8'h0A, 8'h27, 8'hA6}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_addr(input logic [7:0] a);
    @(negedge clk); addr_we = 1; addr_in = a;
    @(negedge clk); addr_we = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; ev = err;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R3 reset state
    check("R3 irq", {7'd0, irq}, 8'd0);
    check("R3 err", {7'd0, err}, 8'd0);
    set_addr(8'h0B); rd(rv); check("R3 regB", rv, 8'h46);
    set_addr(8'h04); rd(rv); check("R3 byte4", rv, 8'h00);
    // R4 toggling on reads of A
    set_addr(8'h0A); rd(rv); check("R4 first read", rv, 8'hA6);
    rd(rv); check("R4 second read", rv, 8'h26);

    // R2 R5 R6 R7 vector table
    foreach (VEC[k]) begin
      set_addr(VEC[k][23:16]);
      wr(VEC[k][15:8]);
      check("R2/R5/R6/R7 err", {7'd0, ev}, {7'd0, VEC[k][24]});
      rd(rv);
      check("R2/R5/R6/R7 data", rv, VEC[k][7:0]);
    end
    // R6 accepted write clears UIP: next read returns 0xA6
    wr(8'h26); check("R6 ok err", {7'd0, ev}, 8'd0);
    rd(rv); check("R6 stored", rv, 8'hA6);

    // R8 generator start, phase kept on rewrite
    set_addr(8'h0B);
    wr(8'h46);
    for (int k = 1; k <= 10; k++) begin
      @(posedge clk); #1;
      check("R8 first period", {7'd0, irq}, {7'd0, k == 10});
    end
    wr(8'h4E);
    for (int k = 12; k <= 29; k++) begin
      @(posedge clk); #1;
      check("R8 phase kept", {7'd0, irq}, {7'd0, k == 20});
    end
    // R9 stop on the expiry edge
    wr(8'h06);
    for (int k = 0; k < 3 * IV; k++) begin
      @(posedge clk); #1;
      check("R9 no pulse after stop", {7'd0, irq}, 8'd0);
    end

    // R10 set-time load
    @(negedge clk);
    ld_sec = 8'h11; ld_min = 8'h22; ld_hour = 8'h13; ld_wday = 3'd3;
    ld_mday = 8'h1F; ld_mon = 4'd11; ld_year = 8'h59; load_en = 1;
    @(negedge clk); load_en = 0;
    set_addr(8'h06); rd(rv); check("R10 weekday", rv, 8'h04);
    set_addr(8'h08); rd(rv); check("R10 month", rv, 8'h0C);
    set_addr(8'h09); rd(rv); check("R10 year", rv, 8'h59);
    set_addr(8'h02); rd(rv); check("R10 minutes", rv, 8'h22);
    // R1 rejected address keeps selection of byte 2
    set_addr(8'h0E); rd(rv); check("R1 reject 0x0E", rv, 8'h22);
    set_addr(8'hFF); rd(rv); check("R1 reject 0xFF", rv, 8'h22);
    // R10 load wins over a same-edge data write
    set_addr(8'h00);
    @(negedge clk); wr_en = 1; wr_data = 8'h77; load_en = 1; ld_sec = 8'h05;
    @(negedge clk); wr_en = 0; load_en = 0;
    rd(rv); check("R10 load priority", rv, 8'h05);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule